// File: doc/BRIEF.md
# System Clock Source Switch and Status Tracker

This block is the control and status side of a system clock manager. Software writes a requested setting: the oscillator that should drive the system clock, the system clock divider, the I/O clock divider, whether the unused oscillator may be powered down, and whether crystal qualification waits for an amplitude detector. The block keeps that request apart from the setting that is actually in force. The applied setting changes to the new source only once the target oscillator reports stable. A pending flag is raised for as long as the two sources disagree.

Divider codes use a 3-bit field. Code n means 32 MHz divided by 2^n, so 000 is 32 MHz and 111 is 0.25 MHz. The RC source delivers only 16 MHz, so a request for code 000 on that source is applied, and reported, as 001. The block also keeps a 2-bit record of the most recent reset cause. It accepts a software-forced warm reset. It owns a clock-loss-detect enable whose copy in an always-on domain settles a fixed number of cycles after each change.

Top module: `clk_src_mgr`

## Requirements
- R1: During and after the synchronous power-on reset `rst`, the outputs are as follows. The requested and active source are RC (`act_src`=1). Both active dividers are 001. Power-down is enabled and amplitude detection is off. `change_pending`=0, `reset_cause`=00, `cld_en`=0 and `cld_valid`=1.
- R2: Source encoding is 0 for the 32 MHz crystal and 1 for the 16 MHz RC oscillator. While no switch is pending and the crystal is active, `act_sys_div` and `act_io_div` equal the requested codes one clock edge after the edge that captured the write.
- R3: Whenever the RC source is active, neither active divider code is below 001. A requested 000 is applied as 001 and every other code is applied as requested.
- R4: `change_pending` is 1 exactly while the requested source differs from the active source.
- R5: A pending switch completes on the first clock edge at which the target oscillator's stable flag is high. `act_src` and both active dividers update on that same edge. While the target is not stable, `act_src` holds.
- R6: `xosc_stable` and `rc_stable` are 1 only while the oscillator is powered and its ready input is high.
- R7: With power-down enabled, an oscillator is powered only while it is the requested or the active source. In that case `osc_pd_sta`=1 whenever no switch is pending. With power-down disabled, both oscillators are powered and `osc_pd_sta`=0.
- R8: With amplitude detection enabled, `xosc_stable` stays 0 until `xosc_amp_ok` is 1.
- R9: `reset_cause` takes the following value from the edge of a reset event: 01 for `ext_rst_evt`, 10 for `wdog_rst_evt`, 11 for `loss_rst_evt` or `force_warm`. When events coincide, the priority is 11 over 10 over 01.
- R10: Every warm reset event returns the requested and active settings to their R1 values on the same edge. A configuration write in that same cycle is discarded. `cld_en` and `reset_cause` are not restored by a warm reset.
- R11: A `force_warm` pulse sets `reset_cause` to 11 and produces a one-cycle `warm_rst_pulse` on the following cycle. Other reset events do not pulse `warm_rst_pulse`.
- R12: A write that changes `cld_en` clears `cld_valid` for AON_LAT (default 4) cycles. Writes to `cld_en` while `cld_valid`=0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_wr | input | 1 | Capture a new requested setting |
| cfg_src | input | 1 | Requested source (0 crystal, 1 RC) |
| cfg_sys_div | input | 3 | Requested system divider code |
| cfg_io_div | input | 3 | Requested I/O divider code |
| cfg_pd | input | 1 | Allow power-down of the unused oscillator |
| cfg_amp_det | input | 1 | Gate crystal stability on the amplitude detector |
| force_warm | input | 1 | Software-forced warm reset |
| ext_rst_evt | input | 1 | External pin reset event |
| wdog_rst_evt | input | 1 | Watchdog reset event |
| loss_rst_evt | input | 1 | Clock-loss reset event |
| cld_wr | input | 1 | Write strobe for the clock-loss-detect enable |
| cld_wdata | input | 1 | Value written to the clock-loss-detect enable |
| xosc_ready | input | 1 | Crystal oscillator running indication |
| xosc_amp_ok | input | 1 | Crystal amplitude above threshold |
| rc_ready | input | 1 | RC oscillator running indication |
| xosc_pwr_en | output | 1 | Crystal oscillator power enable |
| rc_pwr_en | output | 1 | RC oscillator power enable |
| xosc_stable | output | 1 | Crystal qualified stable |
| rc_stable | output | 1 | RC qualified stable |
| osc_pd_sta | output | 1 | One oscillator is powered down |
| act_src | output | 1 | Active source |
| act_sys_div | output | 3 | Applied system divider code |
| act_io_div | output | 3 | Applied I/O divider code |
| change_pending | output | 1 | Source switch requested and not finished |
| reset_cause | output | 2 | Last reset cause |
| warm_rst_pulse | output | 1 | One-cycle pulse after a forced warm reset |
| cld_en | output | 1 | Clock-loss-detect enable |
| cld_valid | output | 1 | Always-on copy matches `cld_en` |

## Verification
A configuration write and a warm reset event can fall on the same clock edge. The block must then give the warm reset precedence and drop the write. The bench provokes this by presenting `cfg_wr` with a crystal request in the same cycle as `ext_rst_evt`. It judges the outcome from the ports: the request must not appear as a pending switch, the active settings must be the defaults, and the cause must read 01. The bench also drives two reset events in one cycle to confirm the cause priority.

// File: rtl/clk_mgr_pkg.sv
package clk_mgr_pkg;

    localparam int DIV_W = 3;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_RC   = 1'b1
    } clk_src_e;

    typedef enum logic [1:0] {
        CAUSE_POWERON = 2'b00,
        CAUSE_PIN     = 2'b01,
        CAUSE_WDOG    = 2'b10,
        CAUSE_LOSS_SW = 2'b11
    } rst_cause_e;

    // Requested setting as written by software.
    typedef struct packed {
        clk_src_e           src;
        logic [DIV_W-1:0]   sys_div;
        logic [DIV_W-1:0]   io_div;
        logic               pd;
        logic               amp_det;
    } clk_req_t;

    // Setting actually in force.
    typedef struct packed {
        clk_src_e           src;
        logic [DIV_W-1:0]   sys_div;
        logic [DIV_W-1:0]   io_div;
    } clk_act_t;

    // Smallest code the 16 MHz RC source can honour.
    localparam logic [DIV_W-1:0] RC_MIN_DIV = DIV_W'(1);

    localparam clk_req_t REQ_DEFAULT = '{src: SRC_RC, sys_div: RC_MIN_DIV,
                                         io_div: RC_MIN_DIV, pd: 1'b1, amp_det: 1'b0};
    localparam clk_act_t ACT_DEFAULT = '{src: SRC_RC, sys_div: RC_MIN_DIV,
                                         io_div: RC_MIN_DIV};

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] code,
                                                   input clk_src_e src);
        if (src == SRC_RC && code < RC_MIN_DIV)
            return RC_MIN_DIV;
        return code;
    endfunction

endpackage

// File: rtl/clk_osc_qual.sv
module clk_osc_qual
    import clk_mgr_pkg::*;
(
    input  clk_src_e req_src,
    input  clk_src_e act_src,
    input  logic     pd,
    input  logic     amp_det,
    input  logic     xosc_ready,
    input  logic     amp_ok,
    input  logic     rc_ready,
    output logic     xosc_pwr,
    output logic     rc_pwr,
    output logic     xosc_stb,
    output logic     rc_stb,
    output logic     pd_sta
);
    // An oscillator in use (requested or active) is never turned off.
    always_comb begin
        xosc_pwr = !pd || req_src == SRC_XTAL || act_src == SRC_XTAL;
        rc_pwr   = !pd || req_src == SRC_RC   || act_src == SRC_RC;
        xosc_stb = xosc_ready && xosc_pwr && (!amp_det || amp_ok);
        rc_stb   = rc_ready && rc_pwr;
        pd_sta   = !(xosc_pwr && rc_pwr);
    end
endmodule

// File: rtl/clk_switch_core.sv
module clk_switch_core
    import clk_mgr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     warm_evt,
    input  logic     cfg_wr,
    input  clk_req_t cfg_in,
    input  logic     xosc_stb,
    input  logic     rc_stb,
    output clk_req_t req,
    output clk_act_t act,
    output logic     pend
);
    logic     tgt_stb;
    clk_src_e nxt_src;

    always_comb begin
        pend    = (req.src != act.src);
        tgt_stb = (req.src == SRC_RC) ? rc_stb : xosc_stb;
        nxt_src = (pend && tgt_stb) ? req.src : act.src;
    end

    always_ff @(posedge clk) begin
        if (rst || warm_evt) begin
            req <= REQ_DEFAULT;
            act <= ACT_DEFAULT;
        end else begin
            if (cfg_wr)
                req <= cfg_in;
            act.src     <= nxt_src;
            act.sys_div <= clamp_div(req.sys_div, nxt_src);
            act.io_div  <= clamp_div(req.io_div, nxt_src);
        end
    end

    // R5: without a stable target the active source does not move
    assert_hold_unstable_R5: assert property (@(posedge clk) disable iff (rst)
        (pend && !tgt_stb && !warm_evt) |=> $stable(act.src));

    // R3: the RC source never carries a code below its minimum
    assert_rc_floor_R3: assert property (@(posedge clk) disable iff (rst)
        (act.src == SRC_RC) |-> (act.sys_div >= RC_MIN_DIV && act.io_div >= RC_MIN_DIV));

    // R10: warm event restores defaults on the next state
    assert_warm_default_R10: assert property (@(posedge clk) disable iff (rst)
        warm_evt |=> (act == ACT_DEFAULT && req == REQ_DEFAULT));
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
    import clk_mgr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_evt,
    input  logic       wdog_evt,
    input  logic       loss_evt,
    input  logic       force_warm,
    output rst_cause_e cause,
    output logic       warm_evt,
    output logic       warm_pulse
);
    always_comb warm_evt = ext_evt || wdog_evt || loss_evt || force_warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause      <= CAUSE_POWERON;
            warm_pulse <= 1'b0;
        end else begin
            warm_pulse <= force_warm;
            if (loss_evt || force_warm)
                cause <= CAUSE_LOSS_SW;
            else if (wdog_evt)
                cause <= CAUSE_WDOG;
            else if (ext_evt)
                cause <= CAUSE_PIN;
        end
    end

    assert_force_cause_R11: assert property (@(posedge clk) disable iff (rst)
        force_warm |=> (warm_pulse && cause == CAUSE_LOSS_SW));

    assert_wdog_prio_R9: assert property (@(posedge clk) disable iff (rst)
        (wdog_evt && !loss_evt && !force_warm) |=> cause == CAUSE_WDOG);
endmodule

// File: rtl/cld_ctrl.sv
module cld_ctrl #(
    parameter int AON_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wdata,
    output logic en,
    output logic valid
);
    localparam int CNT_W = $clog2(AON_LAT + 1);

    logic             aon_copy;
    logic [CNT_W-1:0] cnt;

    always_comb valid = (aon_copy == en);

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            aon_copy <= 1'b0;
            cnt      <= '0;
        end else begin
            if (wr && valid && wdata != en) begin
                en  <= wdata;
                cnt <= CNT_W'(AON_LAT);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1))
                    aon_copy <= en;
            end
        end
    end

    // R12: writes while the copy is out of date leave the enable unchanged
    assert_ignore_invalid_R12: assert property (@(posedge clk) disable iff (rst)
        (wr && !valid) |=> $stable(en));
endmodule

// File: rtl/clk_src_mgr.sv
module clk_src_mgr
    import clk_mgr_pkg::*;
#(
    parameter int AON_LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_src,
    input  logic [DIV_W-1:0] cfg_sys_div,
    input  logic [DIV_W-1:0] cfg_io_div,
    input  logic             cfg_pd,
    input  logic             cfg_amp_det,
    input  logic             force_warm,
    input  logic             ext_rst_evt,
    input  logic             wdog_rst_evt,
    input  logic             loss_rst_evt,
    input  logic             cld_wr,
    input  logic             cld_wdata,
    input  logic             xosc_ready,
    input  logic             xosc_amp_ok,
    input  logic             rc_ready,
    output logic             xosc_pwr_en,
    output logic             rc_pwr_en,
    output logic             xosc_stable,
    output logic             rc_stable,
    output logic             osc_pd_sta,
    output logic             act_src,
    output logic [DIV_W-1:0] act_sys_div,
    output logic [DIV_W-1:0] act_io_div,
    output logic             change_pending,
    output logic [1:0]       reset_cause,
    output logic             warm_rst_pulse,
    output logic             cld_en,
    output logic             cld_valid
);
    clk_req_t   cfg_in, req;
    clk_act_t   act;
    rst_cause_e cause;
    logic       warm_evt;

    always_comb begin
        cfg_in = '{src: clk_src_e'(cfg_src), sys_div: cfg_sys_div,
                   io_div: cfg_io_div, pd: cfg_pd, amp_det: cfg_amp_det};
    end

    rst_cause_rec u_cause (
        .clk       (clk),
        .rst       (rst),
        .ext_evt   (ext_rst_evt),
        .wdog_evt  (wdog_rst_evt),
        .loss_evt  (loss_rst_evt),
        .force_warm(force_warm),
        .cause     (cause),
        .warm_evt  (warm_evt),
        .warm_pulse(warm_rst_pulse)
    );

    clk_osc_qual u_qual (
        .req_src   (req.src),
        .act_src   (act.src),
        .pd        (req.pd),
        .amp_det   (req.amp_det),
        .xosc_ready(xosc_ready),
        .amp_ok    (xosc_amp_ok),
        .rc_ready  (rc_ready),
        .xosc_pwr  (xosc_pwr_en),
        .rc_pwr    (rc_pwr_en),
        .xosc_stb  (xosc_stable),
        .rc_stb    (rc_stable),
        .pd_sta    (osc_pd_sta)
    );

    clk_switch_core u_core (
        .clk     (clk),
        .rst     (rst),
        .warm_evt(warm_evt),
        .cfg_wr  (cfg_wr),
        .cfg_in  (cfg_in),
        .xosc_stb(xosc_stable),
        .rc_stb  (rc_stable),
        .req     (req),
        .act     (act),
        .pend    (change_pending)
    );

    cld_ctrl #(.AON_LAT(AON_LAT)) u_cld (
        .clk  (clk),
        .rst  (rst),
        .wr   (cld_wr),
        .wdata(cld_wdata),
        .en   (cld_en),
        .valid(cld_valid)
    );

    always_comb begin
        act_src     = act.src;
        act_sys_div = act.sys_div;
        act_io_div  = act.io_div;
        reset_cause = cause;
    end

    // R7: settled with power-down on, exactly one oscillator runs
    assert_one_osc_R7: assert property (@(posedge clk) disable iff (rst)
        (req.pd && !change_pending) |-> $countones({xosc_pwr_en, rc_pwr_en}) == 1);

    // R6: the active source's oscillator is always powered
    assert_active_powered_R6: assert property (@(posedge clk) disable iff (rst)
        (act_src == SRC_XTAL) |-> xosc_pwr_en);

    // R5: a completed switch clears the pending flag
    assert_switch_done_R5: assert property (@(posedge clk) disable iff (rst)
        (change_pending && !warm_evt && !cfg_wr && $changed(act_src)) |-> !change_pending);
endmodule

// File: tb/sim_clk_src_mgr.sv
module sim_clk_src_mgr;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 0, cfg_src = 1, cfg_pd = 1, cfg_amp_det = 0;
    logic [2:0] cfg_sys_div = 3'd1, cfg_io_div = 3'd1;
    logic force_warm = 0, ext_rst_evt = 0, wdog_rst_evt = 0, loss_rst_evt = 0;
    logic cld_wr = 0, cld_wdata = 0;
    logic xosc_ready = 0, xosc_amp_ok = 0, rc_ready = 1;
    logic xosc_pwr_en, rc_pwr_en, xosc_stable, rc_stable, osc_pd_sta;
    logic act_src, change_pending, warm_rst_pulse, cld_en, cld_valid;
    logic [2:0] act_sys_div, act_io_div;
    logic [1:0] reset_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    clk_src_mgr u0 (.*);

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(logic src, logic [2:0] sd, logic [2:0] id, logic pd, logic amp);
        cfg_wr = 1; cfg_src = src; cfg_sys_div = sd; cfg_io_div = id;
        cfg_pd = pd; cfg_amp_det = amp;
        step();
        cfg_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1", "act_src", act_src, 1);
        chk("R1", "sys_div", act_sys_div, 1);
        chk("R1", "io_div", act_io_div, 1);
        chk("R1", "pending", change_pending, 0);
        chk("R1", "cause", reset_cause, 0);
        chk("R1", "cld_en", cld_en, 0);
        chk("R1", "cld_valid", cld_valid, 1);
        chk("R7", "xosc off", xosc_pwr_en, 0);
        chk("R7", "pd_sta", osc_pd_sta, 1);
    endtask

    task automatic t_rc_clamp();
        write_cfg(1, 3'd0, 3'd3, 1, 0);
        step();
        chk("R3", "sys clamp 000->001", act_sys_div, 1);
        chk("R3", "io 011 kept", act_io_div, 3);
    endtask

    task automatic t_switch_xtal();
        write_cfg(0, 3'd0, 3'd5, 1, 0);
        chk("R4", "pending after req", change_pending, 1);
        chk("R7", "xosc powered for switch", xosc_pwr_en, 1);
        step(3);
        chk("R5", "src holds while unstable", act_src, 1);
        chk("R6", "xosc not stable", xosc_stable, 0);
        xosc_ready = 1;
        #1 chk("R6", "xosc stable", xosc_stable, 1);
        step();
        chk("R5", "src switched", act_src, 0);
        chk("R5", "sys div with switch", act_sys_div, 0);
        chk("R5", "io div with switch", act_io_div, 5);
        chk("R4", "pending cleared", change_pending, 0);
        chk("R7", "rc off", rc_pwr_en, 0);
        chk("R6", "rc unpowered not stable", rc_stable, 0);
        write_cfg(0, 3'd6, 3'd2, 1, 0);
        step();
        chk("R2", "xtal sys div", act_sys_div, 6);
        chk("R2", "xtal io div", act_io_div, 2);
    endtask

    task automatic t_amp();
        xosc_amp_ok = 0;
        write_cfg(0, 3'd0, 3'd0, 1, 1);
        chk("R8", "gated by amplitude", xosc_stable, 0);
        xosc_amp_ok = 1;
        #1 chk("R8", "amplitude ok", xosc_stable, 1);
    endtask

    task automatic t_no_pd_and_back();
        write_cfg(0, 3'd0, 3'd7, 0, 0);
        chk("R7", "both powered xosc", xosc_pwr_en, 1);
        chk("R7", "both powered rc", rc_pwr_en, 1);
        chk("R7", "pd_sta off", osc_pd_sta, 0);
        write_cfg(1, 3'd0, 3'd7, 0, 0);
        chk("R4", "pending to rc", change_pending, 1);
        step();
        chk("R5", "rc active", act_src, 1);
        chk("R3", "clamped at switch", act_sys_div, 1);
        chk("R5", "io at switch", act_io_div, 7);
    endtask

    task automatic t_causes();
        write_cfg(0, 3'd4, 3'd4, 1, 0);
        ext_rst_evt = 1; step(); ext_rst_evt = 0;
        chk("R9", "pin cause", reset_cause, 1);
        chk("R10", "req restored", change_pending, 0);
        chk("R10", "src restored", act_src, 1);
        wdog_rst_evt = 1; step(); wdog_rst_evt = 0;
        chk("R9", "wdog cause", reset_cause, 2);
        loss_rst_evt = 1; step(); loss_rst_evt = 0;
        chk("R9", "loss cause", reset_cause, 3);
        chk("R11", "no pulse for loss", warm_rst_pulse, 0);
        ext_rst_evt = 1; wdog_rst_evt = 1; step(); ext_rst_evt = 0; wdog_rst_evt = 0;
        chk("R9", "wdog over pin", reset_cause, 2);
    endtask

    task automatic t_force();
        force_warm = 1; step(); force_warm = 0;
        chk("R11", "force cause", reset_cause, 3);
        chk("R11", "pulse high", warm_rst_pulse, 1);
        step();
        chk("R11", "pulse one cycle", warm_rst_pulse, 0);
    endtask

    task automatic t_collide();
        cfg_wr = 1; cfg_src = 0; cfg_sys_div = 3'd5; cfg_io_div = 3'd5;
        ext_rst_evt = 1;
        step();
        cfg_wr = 0; ext_rst_evt = 0;
        chk("R10", "write dropped no pending", change_pending, 0);
        chk("R10", "sys default", act_sys_div, 1);
        chk("R9", "cause pin", reset_cause, 1);
        step();
        chk("R10", "still defaults", act_io_div, 1);
    endtask

    task automatic t_cld();
        cld_wr = 1; cld_wdata = 1; step();
        chk("R12", "en set", cld_en, 1);
        chk("R12", "valid low", cld_valid, 0);
        cld_wdata = 0; step(); cld_wr = 0;
        chk("R12", "write ignored", cld_en, 1);
        step(2);
        chk("R12", "valid still low", cld_valid, 0);
        step();
        chk("R12", "valid back", cld_valid, 1);
        force_warm = 1; step(); force_warm = 0;
        chk("R10", "cld kept over warm", cld_en, 1);
        cld_wr = 1; cld_wdata = 0; step(); cld_wr = 0;
        chk("R12", "en cleared", cld_en, 0);
    endtask

    initial begin
        step(3);
        rst = 0;
        step();
        t_reset();
        t_rc_clamp();
        t_switch_xtal();
        t_amp();
        t_no_pd_and_back();
        t_causes();
        t_force();
        t_collide();
        t_cld();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule